// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block sits between a synchronous host and an asynchronous 128K x 8 EPROM and performs one byte read per host request. The host presents a 17-bit byte address together with a type select. The type select picks either an ordinary array read or an identifier read, which returns the maker code or the device code. The controller lowers chip-enable with the address, lowers output-enable later, and latches the data bus once both access windows have elapsed. It then returns the byte with a single-cycle strobe and keeps the bus quiet while the memory's drivers release.

Every wait is a whole number of clock cycles. Each is derived at elaboration from the clock period and from a grade parameter that selects the fast or slow timing set. While idle, the memory is left deselected, so its outputs float no matter what the other strobes do.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While `busy` is low, `mem_ce_n` and `mem_oe_n` are high, `mem_a9_hv` is low and `rsp_valid` is low. This is also the state right after reset.
- R2: A request (`req_valid` high at a rising edge) is taken only while `busy` is low. A request made while `busy` is high starts no access and produces no response.
- R3: `mem_ce_n` falls at the first rising edge after an accepted request, together with `busy`. `mem_addr` carries the request address from that edge and holds it unchanged for as long as `mem_ce_n` stays low.
- R4: The data byte is latched at the edge where `mem_oe_n` rises. By that edge `mem_ce_n` has been low for at least the chip-enable/address access time, and `mem_oe_n` has been low for at least the output-enable access time. These are 90 ns and 40 ns for the fast grade (`FAST_GRADE`=1), and 120 ns and 55 ns for the slow grade.
- R5: `rsp_valid` is high for exactly one cycle, in the cycle after the latching edge, with the latched byte on `rsp_data`. `mem_ce_n` and `mem_oe_n` return high at that same edge.
- R6: `mem_oe_n` is low only while `mem_ce_n` is low.
- R7: After `mem_oe_n` rises, `busy` stays high and `mem_ce_n` stays high for at least the bus-release time: 25 ns (fast) or 30 ns (slow).
- R8: An identifier read (`req_id`=1) drives all `mem_addr` bits to 0 except bit 0, which is taken from the request. `mem_a9_hv` is high for the whole time `mem_ce_n` is low and falls when the access ends. The memory answers 0xDA when bit 0 is 0 and 0x01 when it is 1.
- R9: `mem_pgm_n` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_addr | input | 17 | Byte address |
| req_id | input | 1 | 1 = identifier read, 0 = array read |
| busy | output | 1 | Access or bus release in progress |
| rsp_valid | output | 1 | One-cycle strobe for `rsp_data` |
| rsp_data | output | 8 | Byte read |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_pgm_n | output | 1 | Memory program strobe, held high |
| mem_a9_hv | output | 1 | Request to raise address line 9 to the high identifier level |
| mem_data_i | input | 8 | Memory data bus |

## Verification
On every cycle, properties check the following:
- output-enable is never active without chip-enable;
- the address is steady through an access and cannot move while `busy` is high;
- the high-voltage request stays inside the chip-enable window;
- the controller is quiet whenever it is not busy;
- the response strobe lasts a single cycle.

The bench's scenarios are needed for everything measured in nanoseconds: the access durations at the latching edge and the release gap before the next chip-enable. Only the scenarios can also show that the right byte was latched, and that a request made mid-access really vanished.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_OEN  = 2'd2,
    ST_TURN = 2'd3
  } rd_state_e;

  function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned floor_one(int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/eprom_wait_timer.sv
module eprom_wait_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R4: an expired count rests at zero until reloaded
  p_count_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/eprom_rd_fsm.sv
module eprom_rd_fsm
  import eprom_rd_pkg::*;
#(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned PRE_CYC = 13,
  parameter int unsigned OE_CYC  = 10,
  parameter int unsigned DF_CYC  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_id,
  input  logic             expired,
  output logic             accept,
  output logic             sample,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             ce_n,
  output logic             oe_n,
  output logic             hv_req,
  output logic             busy
);

  localparam logic [CNT_W-1:0] PRE_LD = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] OE_LD  = CNT_W'(OE_CYC - 1);
  localparam logic [CNT_W-1:0] DF_LD  = CNT_W'(DF_CYC - 1);

  rd_state_e state_q, state_d;
  logic      id_q, id_d;
  logic      ce_n_q, oe_n_q, hv_q, busy_q;
  logic      in_access_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    sample   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        accept   = 1'b1;
        load     = 1'b1;
        load_val = PRE_LD;
        state_d  = ST_ADDR;
      end
      ST_ADDR: if (expired) begin
        load     = 1'b1;
        load_val = OE_LD;
        state_d  = ST_OEN;
      end
      ST_OEN: if (expired) begin
        sample   = 1'b1;
        load     = 1'b1;
        load_val = DF_LD;
        state_d  = ST_TURN;
      end
      ST_TURN: if (expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    id_d        = accept ? req_id : id_q;
    in_access_d = (state_d == ST_ADDR) || (state_d == ST_OEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      id_q    <= 1'b0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      hv_q    <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      id_q    <= id_d;
      ce_n_q  <= !in_access_d;
      oe_n_q  <= !(state_d == ST_OEN);
      hv_q    <= in_access_d && id_d;
      busy_q  <= (state_d != ST_IDLE);
    end
  end

  assign ce_n   = ce_n_q;
  assign oe_n   = oe_n_q;
  assign hv_req = hv_q;
  assign busy   = busy_q;

  // R8: high-voltage request dropped whenever the controller is idle
  p_hv_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !hv_q);
  // R7: the release phase never reopens the memory
  p_turn_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TURN) |-> (ce_n_q && oe_n_q));

endmodule

// File: rtl/eprom_rd_datapath.sv
module eprom_rd_datapath #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              sample,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_id,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic [ADDR_W-1:0] addr_q, addr_d, id_addr;
  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q;

  always_comb begin
    id_addr    = '0;
    id_addr[0] = req_addr[0];
    addr_d     = addr_q;
    if (accept) addr_d = req_id ? id_addr : req_addr;
    data_d = sample ? mem_data_i : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      vld_q  <= sample;
    end
  end

  assign mem_addr  = addr_q;
  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;

  // R5: response strobe lasts one cycle
  p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R5: returned byte holds between strobes
  p_rsp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(rsp_data));

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter bit          FAST_GRADE    = 1'b1,
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_id,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_pgm_n,
  output logic              mem_a9_hv,
  input  logic [DATA_W-1:0] mem_data_i
);

  localparam int unsigned T_ACC_PS = FAST_GRADE ? 90000 : 120000;
  localparam int unsigned T_OE_PS  = FAST_GRADE ? 40000 : 55000;
  localparam int unsigned T_DF_PS  = FAST_GRADE ? 25000 : 30000;
  localparam int unsigned ACC_CYC  = ceil_div(T_ACC_PS, CLK_PERIOD_PS);
  localparam int unsigned OE_CYC   = floor_one(ceil_div(T_OE_PS, CLK_PERIOD_PS));
  localparam int unsigned DF_CYC   = floor_one(ceil_div(T_DF_PS, CLK_PERIOD_PS));
  localparam int unsigned PRE_CYC  = floor_one((ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0);
  localparam int unsigned CNT_W    = $clog2(max3(PRE_CYC, OE_CYC, DF_CYC) + 1);

  logic             accept, sample, load, expired;
  logic [CNT_W-1:0] load_val;

  eprom_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  eprom_rd_fsm #(
    .CNT_W(CNT_W), .PRE_CYC(PRE_CYC), .OE_CYC(OE_CYC), .DF_CYC(DF_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .expired(expired), .accept(accept), .sample(sample), .load(load),
    .load_val(load_val), .ce_n(mem_ce_n), .oe_n(mem_oe_n),
    .hv_req(mem_a9_hv), .busy(busy)
  );

  eprom_rd_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sample(sample),
    .req_addr(req_addr), .req_id(req_id), .mem_data_i(mem_data_i),
    .mem_addr(mem_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign mem_pgm_n = 1'b1;

  // R6: output-enable only inside chip-enable
  p_oe_in_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n);
  // R3: address steady across an access
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  // R2: no new address while busy
  p_busy_locks_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mem_addr));
  // R8: high-voltage request only with chip-enable
  p_hv_in_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_a9_hv |-> !mem_ce_n);
  // R1: quiet memory interface whenever not busy
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ce_n && mem_oe_n && !mem_a9_hv && !rsp_valid));

endmodule

// File: tb/test_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module test_eprom_rd_ctrl;

  localparam int T_ACC = 90, T_OE = 40, T_DF = 25, PER = 4;
  localparam int DF_MIN_CYC = (T_DF + PER - 1) / PER;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_id = 1'b0;
  logic [16:0] req_addr = '0;
  logic        busy, rsp_valid, mem_ce_n, mem_oe_n, mem_pgm_n, mem_a9_hv;
  logic [7:0]  rsp_data, mem_data_i, mem_val;
  logic [16:0] mem_addr;

  int checks = 0, errors = 0, cyc = 0;
  int ce_fall_cyc = 0, oe_fall_cyc = 0, oe_rise_cyc = -100, req_cyc = 0;
  int n_ce_falls = 0, n_rsp = 0;
  bit ce_prev = 1'b1, oe_prev = 1'b1, busy_prev = 1'b0, win_err = 1'b0, done = 1'b0;
  bit          exp_id = 1'b0, fresh = 1'b0;
  logic [16:0] exp_addr = '0;
  logic [7:0]  exp_data = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eprom_rd_ctrl i_eprom_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_id(req_id), .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_pgm_n(mem_pgm_n), .mem_a9_hv(mem_a9_hv), .mem_data_i(mem_data_i)
  );

  function automatic logic [7:0] img(logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] expect_byte(logic [16:0] a, bit id);
    if (id) return a[0] ? 8'h01 : 8'hDA;
    return img(a);
  endfunction

  // memory model: correct byte while selected and enabled, inverted otherwise
  always_comb mem_val = mem_a9_hv ? (mem_addr[0] ? 8'h01 : 8'hDA) : img(mem_addr);
  assign mem_data_i = (!mem_ce_n && !mem_oe_n) ? mem_val : ~mem_val;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // protocol monitor
  always @(negedge clk) if (rst_n) begin
    if (!mem_oe_n && mem_ce_n) chk(1'b0, "R6 oe without ce", 1, 0);
    if (!mem_ce_n && (mem_a9_hv !== exp_id || (exp_id && mem_addr[16:1] != 0))) win_err = 1'b1;
    if (ce_prev && !mem_ce_n) begin
      n_ce_falls++;
      ce_fall_cyc = cyc;
      win_err = 1'b0;
      chk((cyc - oe_rise_cyc) >= DF_MIN_CYC, "R7 gap before next ce", cyc - oe_rise_cyc, DF_MIN_CYC);
      if (fresh) begin
        chk(cyc == req_cyc + 1, "R3 ce fall cycle", cyc, req_cyc + 1);
        chk(busy == 1'b1, "R3 busy with ce", busy, 1);
        chk(mem_addr == exp_addr, "R3/R8 bus address", mem_addr, exp_addr);
        fresh = 1'b0;
      end
    end
    if (oe_prev && !mem_oe_n) oe_fall_cyc = cyc;
    if (!oe_prev && mem_oe_n) begin
      oe_rise_cyc = cyc;
      chk((cyc - ce_fall_cyc) * PER >= T_ACC, "R4 ce-to-latch ns", (cyc - ce_fall_cyc) * PER, T_ACC);
      chk((cyc - oe_fall_cyc) * PER >= T_OE, "R4 oe-to-latch ns", (cyc - oe_fall_cyc) * PER, T_OE);
      chk(rsp_valid == 1'b1, "R5 strobe at oe rise", rsp_valid, 1);
      chk(rsp_data == exp_data, "R5/R8 data", rsp_data, exp_data);
      chk(mem_ce_n == 1'b1, "R5 ce released", mem_ce_n, 1);
      chk(!win_err && !mem_a9_hv, "R8 hv window", win_err, 0);
      chk(mem_pgm_n == 1'b1, "R9 pgm high", mem_pgm_n, 1);
    end
    if (rsp_valid) n_rsp++;
    if (busy_prev && !busy)
      chk((cyc - oe_rise_cyc) * PER >= T_DF, "R7 busy through release", (cyc - oe_rise_cyc) * PER, T_DF);
    if (!busy) chk(mem_ce_n && mem_oe_n && !mem_a9_hv && !rsp_valid, "R1 idle quiet", {mem_ce_n, mem_oe_n}, 3);
    ce_prev = mem_ce_n; oe_prev = mem_oe_n; busy_prev = busy;
  end

  task automatic do_read(input logic [16:0] a, input bit id);
    @(negedge clk);
    while (busy) @(negedge clk);
    exp_id   = id;
    exp_addr = id ? {16'd0, a[0]} : a;
    exp_data = expect_byte(a, id);
    req_addr = a; req_id = id; req_valid = 1'b1;
    req_cyc  = cyc; fresh = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    int unsigned seed_val;
    int f0, r0;
    seed_val = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_ce_n === 1'b1 && mem_oe_n === 1'b1, "R1 reset strobes", {mem_ce_n, mem_oe_n}, 3);
    chk(mem_a9_hv === 1'b0 && busy === 1'b0 && rsp_valid === 1'b0, "R1 reset flags",
        {mem_a9_hv, busy, rsp_valid}, 0);
    chk(mem_pgm_n === 1'b1, "R9 pgm in reset", mem_pgm_n, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    do_read(17'h00000, 1'b0); wait_idle();
    do_read(17'h1FFFF, 1'b0); wait_idle();
    do_read(17'h00000, 1'b1); wait_idle();   // R8 maker code
    do_read(17'h1FFFF, 1'b1); wait_idle();   // R8 device code, upper bits forced low
    do_read(17'h0A5A4, 1'b1); wait_idle();
    // R2: request during busy is dropped
    f0 = n_ce_falls; r0 = n_rsp;
    do_read(17'h12345, 1'b0);
    repeat (3) @(negedge clk);
    req_addr = 17'h0BEEF; req_id = 1'b1; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk(n_ce_falls == f0 + 1, "R2 accesses after busy request", n_ce_falls - f0, 1);
    chk(n_rsp == r0 + 1, "R2 responses after busy request", n_rsp - r0, 1);
    // R2: request held high all through an access starts nothing extra
    f0 = n_ce_falls;
    do_read(17'h00777, 1'b0);
    req_valid = 1'b1; req_addr = 17'h1C001;
    while (busy) @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(n_ce_falls == f0 + 1, "R2 held request while busy", n_ce_falls - f0, 1);
    // random mix
    for (int i = 0; i < 60; i++) begin
      do_read(17'($urandom), ($urandom % 4) == 0);
      if ($urandom % 2) wait_idle();
    end
    wait_idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * PER);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule